// File: doc/BRIEF.md
# Windowed Pixel Readout Sequencer

This block sets the readout order for a 640 x 480 pixel array that is scanned progressively inside a window software can program. Four registers hold the window. The horizontal start and the width are counted in 8-pixel units. The vertical start and the height are counted in rows. The window is clipped so that it always stays inside the array. A write changes only a shadow copy of a register. The sequencer takes a copy of the shadow values only when a new frame is started, so a frame that is already running always uses the window it began with.

During a frame the sequencer walks the window's rows from top to bottom. In each row it walks the 4 x 1 pixel kernels from left to right. For each kernel it raises a request that carries the row index and the kernel column index. Four conversion lanes answer with one 10-bit sample each, all at the same time. The block then puts the four samples onto a single output bus over four back-to-back cycles, with lane 0 first. A kernel is fetched only when the lanes mark their samples valid, so a slow source stalls the output and no pixel is lost or repeated. Each pixel on the bus carries a frame-start marker, a line-start marker and a valid flag.

Top module: `win_readout_seq`

## Requirements
- R1: After reset, pix_valid, pix_sof, pix_sol, req_valid and frame_busy are all low.
- R2: The output stream of a frame lists the window pixels row by row, from top to bottom. Within a row the column rises by one per pixel. There are no extra pixels and no missing pixels.
- R3: Register address 0 holds the horizontal start in 8-pixel units, so the first column is 8 times its value. Register address 1 holds the first row.
- R4: Register address 2 holds the width in 8-pixel units. Register address 3 holds the height in rows. A value of 0 in either one is treated as 1.
- R5: The window is clipped to the array. A horizontal start above 79 becomes 79 and a vertical start above 479 becomes 479. The width and the height are then cut so that the window ends at or before column 639 and row 479.
- R6: A register write affects only frames started after the write. A pulse on frame_go while no frame is active copies the registers and starts a frame, and frame_busy goes high on the next clock edge. Writes made during a frame do not change that frame.
- R7: A frame_go pulse while frame_busy is high is ignored. The running frame is neither restarted nor changed, and no second frame follows it.
- R8: req_valid presents req_row and req_kcol, where the kernel column index is the column of the kernel's first pixel divided by 4. The kernel is taken on a clock edge where req_valid and lane_valid are both high. Bits [10i+9:10i] of lane_data carry the pixel at column 4*req_kcol+i.
- R9: While lane_valid is low no kernel is taken, and the output pauses after the kernel in progress. A stall never causes a lost, repeated or reordered pixel.
- R10: pix_sof is high together with the first pixel of the frame. pix_sol is high together with the first pixel of every row. Neither marker is ever high without pix_valid.
- R11: With lane_valid held high, the first pixel is on the bus two cycles after the edge that samples frame_go. The frame's pixels then follow on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a window register |
| cfg_addr | input | 2 | Register select: 0 x start, 1 y start, 2 width, 3 height |
| cfg_wdata | input | 16 | Write value |
| frame_go | input | 1 | Starts a frame when none is active |
| frame_busy | output | 1 | High while kernels of the frame remain to be fetched |
| req_valid | output | 1 | A kernel request is presented |
| req_row | output | 9 | Row of the requested kernel |
| req_kcol | output | 8 | Kernel column index of the requested kernel |
| lane_valid | input | 1 | The four lane samples for the request are present |
| lane_data | input | 40 | Four 10-bit samples, lane i in bits [10i+9:10i] |
| pix_valid | output | 1 | A window pixel is on the bus |
| pix_data | output | 10 | Pixel sample |
| pix_sof | output | 1 | First pixel of the frame |
| pix_sol | output | 1 | First pixel of a row |

## Verification
A kernel request is visible in the cycle after frame_go is sampled, or in the cycle after the previous kernel is taken. The four pixels of a taken kernel are on the bus one to four cycles after the edge that takes it. To keep to this timing, the bench checks each request and each pixel on the falling edge of the same cycle in which the design shows it. It keeps its own fetch pointer, advanced only where it drove lane_valid high against a visible request, and its own pixel pointer, advanced on every observed pixel. With full-rate lanes it also checks the exact distance of two cycles from frame_go and the absence of gaps. At the end of each frame it compares the pixel count with the count the window should give.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
   localparam int CFG_W = 16;
   typedef logic [CFG_W-1:0] cfg_word_t;
   typedef enum logic [1:0] {
      REG_XSTART = 2'd0,
      REG_YSTART = 2'd1,
      REG_WIDTH  = 2'd2,
      REG_HEIGHT = 2'd3
   } cfg_reg_e;
   typedef struct packed {
      cfg_word_t xs;
      cfg_word_t ys;
      cfg_word_t w;
      cfg_word_t h;
   } win_shadow_t;
endpackage

// File: rtl/wrs_cfg.sv
module wrs_cfg
   import wrs_pkg::*;
#(
   parameter int COLS  = 640,
   parameter int ROWS  = 480,
   parameter int LANES = 4,
   parameter int XSTEP = 8,
   localparam int KW   = $clog2(COLS/LANES + 1),
   localparam int RW   = $clog2(ROWS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    addr,
   input  cfg_word_t     wdata,
   output logic [KW-1:0] kstart,
   output logic [KW-1:0] klast,
   output logic [RW-1:0] rstart,
   output logic [RW-1:0] rlast
);
   localparam int        XU    = COLS / XSTEP;
   localparam int        KPU   = XSTEP / LANES;
   localparam cfg_word_t XU16  = cfg_word_t'(XU);
   localparam cfg_word_t ROW16 = cfg_word_t'(ROWS);

   win_shadow_t sh_q;
   logic [KW-1:0] xs_n, wq, wroom, wu;
   logic [RW-1:0] ys_n, hq, hroom, hu;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (we) begin
         case (cfg_reg_e'(addr))
            REG_XSTART: sh_q.xs <= wdata;
            REG_YSTART: sh_q.ys <= wdata;
            REG_WIDTH:  sh_q.w  <= wdata;
            REG_HEIGHT: sh_q.h  <= wdata;
            default:    sh_q    <= sh_q;
         endcase
      end
   end

   always_comb begin
      xs_n   = (sh_q.xs >= XU16) ? KW'(XU - 1) : sh_q.xs[KW-1:0];
      wq     = (sh_q.w == '0) ? KW'(1) :
               (sh_q.w >= XU16) ? KW'(XU) : sh_q.w[KW-1:0];
      wroom  = KW'(XU) - xs_n;
      wu     = (wq > wroom) ? wroom : wq;
      kstart = xs_n * KW'(KPU);
      klast  = kstart + wu * KW'(KPU) - KW'(1);
      ys_n   = (sh_q.ys >= ROW16) ? RW'(ROWS - 1) : sh_q.ys[RW-1:0];
      hq     = (sh_q.h == '0) ? RW'(1) :
               (sh_q.h >= ROW16) ? RW'(ROWS) : sh_q.h[RW-1:0];
      hroom  = RW'(ROWS) - ys_n;
      hu     = (hq > hroom) ? hroom : hq;
      rstart = ys_n;
      rlast  = ys_n + hu - RW'(1);
   end

   p_clip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (klast >= kstart) && (klast < KW'(COLS/LANES)) && (rlast >= rstart) && (rlast < RW'(ROWS)));
endmodule

// File: rtl/wrs_walk.sv
module wrs_walk #(
   parameter int COLS  = 640,
   parameter int ROWS  = 480,
   parameter int LANES = 4,
   localparam int KW   = $clog2(COLS/LANES + 1),
   localparam int RW   = $clog2(ROWS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [KW-1:0] kstart,
   input  logic [KW-1:0] klast,
   input  logic [RW-1:0] rstart,
   input  logic [RW-1:0] rlast,
   input  logic          ser_ready,
   input  logic          lane_valid,
   output logic          active,
   output logic          req_valid,
   output logic [RW-1:0] req_row,
   output logic [KW-1:0] req_kcol,
   output logic          take,
   output logic          first_line,
   output logic          first_frame
);
   logic [KW-1:0] kcol_q, ks_q, kl_q;
   logic [RW-1:0] row_q, rs_q, rl_q;

   assign req_valid   = active && ser_ready;
   assign take        = req_valid && lane_valid;
   assign req_row     = row_q;
   assign req_kcol    = kcol_q;
   assign first_line  = (kcol_q == ks_q);
   assign first_frame = first_line && (row_q == rs_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         kcol_q <= '0;
         row_q  <= '0;
         ks_q   <= '0;
         kl_q   <= '0;
         rs_q   <= '0;
         rl_q   <= '0;
      end else if (go && !active) begin
         active <= 1'b1;
         kcol_q <= kstart;
         row_q  <= rstart;
         ks_q   <= kstart;
         kl_q   <= klast;
         rs_q   <= rstart;
         rl_q   <= rlast;
      end else if (take) begin
         if (kcol_q == kl_q) begin
            kcol_q <= ks_q;
            if (row_q == rl_q) active <= 1'b0;
            else               row_q  <= row_q + RW'(1);
         end else begin
            kcol_q <= kcol_q + KW'(1);
         end
      end
   end

   p_win_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      active && $past(active) |-> $stable(ks_q) && $stable(kl_q) && $stable(rs_q) && $stable(rl_q));
   p_go_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      go && active |=> $stable(ks_q) && $stable(rl_q));
   p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (kcol_q >= ks_q) && (kcol_q <= kl_q) && (row_q >= rs_q) && (row_q <= rl_q));
endmodule

// File: rtl/wrs_ser.sv
module wrs_ser #(
   parameter int LANES = 4,
   parameter int DW    = 10,
   localparam int PW   = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [LANES*DW-1:0] lane_data,
   input  logic                sol_in,
   input  logic                sof_in,
   output logic                ready,
   output logic                pix_valid,
   output logic [DW-1:0]       pix_data,
   output logic                pix_sof,
   output logic                pix_sol
);
   localparam logic [PW-1:0] LAST = PW'(LANES - 1);

   logic [LANES-1:0][DW-1:0] lanes, smp_q;
   logic [PW-1:0]            ph_q;
   logic                     busy_q, sol_q, sof_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = lane_data[g*DW +: DW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_q  <= '0;
         ph_q   <= '0;
         busy_q <= 1'b0;
         sol_q  <= 1'b0;
         sof_q  <= 1'b0;
      end else if (load) begin
         smp_q  <= lanes;
         ph_q   <= '0;
         busy_q <= 1'b1;
         sol_q  <= sol_in;
         sof_q  <= sof_in;
      end else if (busy_q) begin
         if (ph_q == LAST) busy_q <= 1'b0;
         else              ph_q   <= ph_q + PW'(1);
      end
   end

   assign ready     = !busy_q || (ph_q == LAST);
   assign pix_valid = busy_q;
   assign pix_data  = smp_q[ph_q];
   assign pix_sol   = busy_q && (ph_q == '0) && sol_q;
   assign pix_sof   = busy_q && (ph_q == '0) && sof_q;

   p_load_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> ready);
   p_beats_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && (ph_q != LAST) |=> pix_valid);
   p_marks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_sof |-> pix_sol) and (pix_sol |-> pix_valid));
endmodule

// File: rtl/win_readout_seq.sv
module win_readout_seq
   import wrs_pkg::*;
#(
   parameter int COLS  = 640,
   parameter int ROWS  = 480,
   parameter int LANES = 4,
   parameter int XSTEP = 8,
   parameter int DW    = 10
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic [1:0]                      cfg_addr,
   input  logic [CFG_W-1:0]                cfg_wdata,
   input  logic                            frame_go,
   output logic                            frame_busy,
   output logic                            req_valid,
   output logic [$clog2(ROWS+1)-1:0]       req_row,
   output logic [$clog2(COLS/LANES+1)-1:0] req_kcol,
   input  logic                            lane_valid,
   input  logic [LANES*DW-1:0]             lane_data,
   output logic                            pix_valid,
   output logic [DW-1:0]                   pix_data,
   output logic                            pix_sof,
   output logic                            pix_sol
);
   localparam int KW = $clog2(COLS/LANES + 1);
   localparam int RW = $clog2(ROWS + 1);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (XSTEP % LANES != 0 || COLS % XSTEP != 0) begin : g_bad_step
      $error("XSTEP must be a multiple of LANES and divide COLS");
   end
   if (ROWS < 1 || (COLS / XSTEP) >= (1 << CFG_W)) begin : g_bad_size
      $error("array size does not fit the register width");
   end

   logic [KW-1:0] kstart, klast;
   logic [RW-1:0] rstart, rlast;
   logic          ser_ready, take, first_line, first_frame;

   wrs_cfg #(.COLS(COLS), .ROWS(ROWS), .LANES(LANES), .XSTEP(XSTEP)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .kstart(kstart), .klast(klast), .rstart(rstart), .rlast(rlast));

   wrs_walk #(.COLS(COLS), .ROWS(ROWS), .LANES(LANES)) u_walk (
      .clk(clk), .rst_n(rst_n), .go(frame_go),
      .kstart(kstart), .klast(klast), .rstart(rstart), .rlast(rlast),
      .ser_ready(ser_ready), .lane_valid(lane_valid), .active(frame_busy),
      .req_valid(req_valid), .req_row(req_row), .req_kcol(req_kcol),
      .take(take), .first_line(first_line), .first_frame(first_frame));

   wrs_ser #(.LANES(LANES), .DW(DW)) u_ser (
      .clk(clk), .rst_n(rst_n), .load(take), .lane_data(lane_data),
      .sol_in(first_line), .sof_in(first_frame), .ready(ser_ready),
      .pix_valid(pix_valid), .pix_data(pix_data), .pix_sof(pix_sof), .pix_sol(pix_sol));

   p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go && !frame_busy |=> frame_busy);
   p_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> frame_busy);
endmodule

// File: tb/sim_win_readout_seq.sv
module sim_win_readout_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        frame_go = 1'b0;
   logic        frame_busy, req_valid, lane_valid = 1'b0;
   logic [8:0]  req_row;
   logic [7:0]  req_kcol;
   logic [39:0] lane_data = '0;
   logic        pix_valid, pix_sof, pix_sol;
   logic [9:0]  pix_data;

   int total = 0, bad = 0, cyc = 0, pct = 100;
   int m_ks, m_kl, m_rs, m_rl, m_n;
   int prow, pcol, pleft, qrow, qk;
   int go_cyc, first_cyc, last_cyc, seen;
   string tag = "R2";

   always #4 clk = ~clk;

   win_readout_seq u0 (.*);

   function automatic int pixv(int r, int c);
      return (r * 37 + c * 5 + 3) % 1024;
   endfunction

   task automatic chk(bit ok, string t, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
      end
   endtask

   task automatic wr(int a, int v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(v);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_win(int xs, int ys, int w, int h);
      wr(0, xs); wr(1, ys); wr(2, w); wr(3, h);
   endtask

   // model: clip in units of 8 pixels and rows, kernel index = column / 4
   task automatic start_frame(int xs, int ys, int w, int h, int p, string t);
      int xu, wu, hu, yr;
      xu = (xs > 79) ? 79 : xs;
      wu = (w == 0) ? 1 : w;
      if (wu > 80 - xu) wu = 80 - xu;
      yr = (ys > 479) ? 479 : ys;
      hu = (h == 0) ? 1 : h;
      if (hu > 480 - yr) hu = 480 - yr;
      m_ks = xu * 2; m_kl = m_ks + wu * 2 - 1; m_rs = yr; m_rl = yr + hu - 1;
      m_n = wu * 8 * hu;
      prow = m_rs; pcol = m_ks * 4; pleft = m_n; qrow = m_rs; qk = m_ks;
      seen = 0; pct = p; tag = t;
      @(negedge clk);
      frame_go = 1'b1; go_cyc = cyc;
      @(negedge clk);
      frame_go = 1'b0;
   endtask

   task automatic finish_frame();
      while (pleft > 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(seen == m_n, tag, "pixel count", seen, m_n);
      chk(frame_busy == 1'b0, "R7", "busy after frame", int'(frame_busy), 0);
      if (pct == 100) begin
         chk(first_cyc - go_cyc == 2, "R11", "first pixel latency", first_cyc - go_cyc, 2);
         chk(last_cyc - first_cyc == m_n - 1, "R11", "gapless span", last_cyc - first_cyc, m_n - 1);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // lane model and request check (R8)
   always @(negedge clk) begin
      if (rst_n && req_valid) begin
         chk(int'(req_row) == qrow && int'(req_kcol) == qk, "R8", "request row*1000+kcol",
             int'(req_row) * 1000 + int'(req_kcol), qrow * 1000 + qk);
         lane_valid = (($urandom % 100) < pct);
         for (int i = 0; i < 4; i++) lane_data[i*10 +: 10] = 10'(pixv(int'(req_row), int'(req_kcol) * 4 + i));
         if (lane_valid) begin
            if (qk == m_kl) begin qk = m_ks; qrow++; end
            else qk++;
         end
      end else begin
         lane_valid = (($urandom % 100) < pct);
         lane_data = {$urandom, $urandom};
      end
   end

   // output stream check (R2, R9, R10)
   always @(negedge clk) begin
      if (rst_n) begin
         chk(!(pix_sol || pix_sof) || pix_valid, "R10", "marker without valid",
             int'(pix_sol || pix_sof), 0);
         if (pix_valid) begin
            if (pleft == 0) begin
               chk(1'b0, tag, "unexpected pixel", int'(pix_data), -1);
            end else begin
               if (seen == 0) first_cyc = cyc;
               last_cyc = cyc;
               chk(int'(pix_data) == pixv(prow, pcol), tag, "pixel value",
                   int'(pix_data), pixv(prow, pcol));
               chk(pix_sol == (pcol == m_ks * 4) && pix_sof == (seen == 0), "R10",
                   "sof*2+sol", int'(pix_sof) * 2 + int'(pix_sol),
                   int'(seen == 0) * 2 + int'(pcol == m_ks * 4));
               seen++; pleft--;
               if (pcol == m_kl * 4 + 3) begin pcol = m_ks * 4; prow++; end
               else pcol++;
            end
         end
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(!pix_valid && !pix_sof && !pix_sol && !req_valid && !frame_busy, "R1",
          "idle outputs after reset", int'({pix_valid, pix_sof, pix_sol, req_valid, frame_busy}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 / R3 basic window, full rate
      set_win(3, 10, 2, 3);
      start_frame(3, 10, 2, 3, 100, "R3");
      finish_frame();
      // R4 zero width/height
      set_win(0, 0, 0, 0);
      start_frame(0, 0, 0, 0, 100, "R4");
      finish_frame();
      // R5 clipping at right/bottom and oversize start
      set_win(78, 470, 50, 100);
      start_frame(78, 470, 50, 100, 100, "R5");
      finish_frame();
      set_win(1000, 9000, 3, 2);
      start_frame(1000, 9000, 3, 2, 100, "R5");
      finish_frame();
      // R6 writes during a frame do not alter it; R7 extra go ignored
      set_win(5, 20, 4, 4);
      start_frame(5, 20, 4, 4, 100, "R6");
      repeat (8) @(negedge clk);
      wr(0, 1); wr(1, 2); wr(2, 1); wr(3, 1);
      frame_go = 1'b1;
      @(negedge clk);
      frame_go = 1'b0;
      finish_frame();
      repeat (4) @(negedge clk);
      chk(!frame_busy && !pix_valid, "R7", "no second frame", int'(frame_busy), 0);
      // new registers apply to the next frame
      start_frame(1, 2, 1, 1, 100, "R6");
      finish_frame();
      // R9 stalls, random windows
      for (int k = 0; k < 8; k++) begin
         int xs, ys, w, h, p;
         xs = $urandom % 90; ys = $urandom % 500; w = $urandom % 5; h = $urandom % 9;
         p = 20 + ($urandom % 70);
         set_win(xs, ys, w, h);
         start_frame(xs, ys, w, h, p, "R9");
         finish_frame();
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule